// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by a 15-bit programmable ratio and gives one output pulse for every N input cycles. It is meant to sit behind a synthesizer's RF front end and ahead of a phase comparator. Inside, a dual-modulus prescaler divides by 8 or by 9. A 3-bit swallow counter picks how many prescaler cycles of each output period use the longer modulus. A 12-bit main counter sets how many prescaler cycles make up one output period.

The ratio word is split into fields. The upper 12 bits form the main count M and the lower 3 bits form the swallow count A, so N = 8·M + A. A control interface delivers a new word with a one-cycle load strobe. The word waits in a holding register until the current output period has finished. A half-rate copy of the output can be put on a test pin.

Top module: `pswallow_div`

## Requirements
- R1: While `rst` is high and after it falls, `div_pulse_o`, `div_half_o`, `test_o` and `ratio_bad_o` are 0. No output pulse appears until a ratio has been loaded.
- R2: With ratio word bits [14:3] = M and bits [2:0] = A, M ≥ 1 and A ≤ M, consecutive rising edges of `div_pulse_o` are exactly 8·M + A clock cycles apart.
- R3: `div_pulse_o` is high for exactly one clock cycle per output period.
- R4: A word presented with `ratio_ld_i` high becomes active at the end of the output period in progress, and that period finishes at the old ratio. The first load after reset starts counting at once.
- R5: `div_half_o` starts at 0 and toggles in the same cycle that `div_pulse_o` is high, so it runs at half the output rate.
- R6: `test_o` equals `div_half_o` delayed by one cycle when `test_en_i` was 1 in the previous cycle, and is 0 otherwise.
- R7: `ratio_bad_o` is 1 while the active word has M = 0 or M < A, and 0 otherwise. Output periods for such words are unspecified.
- R8: The extreme valid ratios 8 (M=1, A=0) and 32767 (all ones) give periods of 8 and 32767 cycles.
- R9: The gap between output pulses never exceeds 9·4096 + 4 cycles after a load, whatever word was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_i | input | 15 | Ratio word: main count in [14:3], swallow count in [2:0] |
| ratio_ld_i | input | 1 | One-cycle strobe that captures `ratio_i` |
| test_en_i | input | 1 | Routes the half-rate output to `test_o` |
| div_pulse_o | output | 1 | One-cycle pulse per N input cycles |
| div_half_o | output | 1 | Divider output divided by two |
| test_o | output | 1 | Gated half-rate copy for the test pin |
| ratio_bad_o | output | 1 | Active ratio word is outside the valid range |

## Verification
Several properties are checked on every cycle by the assertions:
- the output pulse is always one cycle wide;
- the half-rate signal changes exactly with each pulse and holds otherwise;
- the test pin stays low unless it was enabled in the previous cycle;
- the spacing between pulses stays bounded.

The exact period 8·M + A can only be shown by the bench's scenarios. The same holds for the deferral of a new ratio to the period boundary and the validity flag. The bench measures these by counting cycles between pulses over a sweep of main and swallow counts, a mid-period reload, an invalid word and the extreme ratios.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int SW_W    = 3;
  localparam int MN_W    = 12;
  localparam int RATIO_W = SW_W + MN_W;

  typedef struct packed {
    logic [MN_W-1:0] m;
    logic [SW_W-1:0] a;
  } ratio_t;

  // A word is usable when the main count is nonzero and covers the swallow count.
  function automatic logic ratio_ok(ratio_t r);
    return (r.m != '0) && (r.m >= {{(MN_W-SW_W){1'b0}}, r.a});
  endfunction
endpackage

// File: rtl/dm_prescaler.sv
module dm_prescaler
  import pswallow_pkg::*;
#(
  parameter int PW = SW_W
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic load_i,
  input  logic mod9_i,
  output logic tick_o
);
  localparam logic [PW:0] BASE = (PW+1)'(1) << PW;
  localparam logic [PW:0] ONE  = (PW+1)'(1);

  logic [PW:0] pcnt;

  assign tick_o = run_i && (pcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
    end else if (load_i || tick_o) begin
      pcnt <= mod9_i ? BASE : BASE - ONE;
    end else if (run_i) begin
      pcnt <= pcnt - ONE;
    end
  end
endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import pswallow_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load_i,
  input  ratio_t ratio_i,
  input  logic   tick_i,
  output logic   mod9_o,
  output logic   last_o
);
  logic [MN_W-1:0] mcnt;
  logic [SW_W-1:0] acnt;

  assign last_o = tick_i && (mcnt == MN_W'(1));

  // Modulus for the prescaler cycle that begins at the coming edge.
  always_comb begin
    if (load_i)      mod9_o = (ratio_i.a != '0);
    else if (tick_i) mod9_o = (acnt > SW_W'(1));
    else             mod9_o = (acnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcnt <= '0;
      acnt <= '0;
    end else if (load_i) begin
      mcnt <= ratio_i.m;
      acnt <= ratio_i.a;
    end else if (tick_i) begin
      mcnt <= mcnt - MN_W'(1);
      if (acnt != '0) acnt <= acnt - SW_W'(1);
    end
  end
endmodule

// File: rtl/ratio_store.sv
module ratio_store
  import pswallow_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ld_i,
  input  ratio_t ratio_i,
  input  logic   roll_i,
  output logic   start_o,
  output logic   running_o,
  output ratio_t next_o
);
  ratio_t pend;
  ratio_t active;
  logic   pend_v;

  assign start_o = !running_o && pend_v;
  assign next_o  = pend_v ? pend : active;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      active    <= '0;
      pend_v    <= 1'b0;
      running_o <= 1'b0;
    end else begin
      if (ld_i) pend <= ratio_i;
      pend_v <= ld_i || (pend_v && !(start_o || roll_i));
      if (start_o || roll_i) active <= next_o;
      if (start_o) running_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               ratio_ld_i,
  input  logic               test_en_i,
  output logic               div_pulse_o,
  output logic               div_half_o,
  output logic               test_o,
  output logic               ratio_bad_o
);
  logic   start;
  logic   running;
  logic   last;
  logic   tick;
  logic   mod9;
  logic   cyc_load;
  ratio_t next_ratio;

  assign cyc_load = start || last;

  ratio_store u_store (
    .clk       (clk),
    .rst       (rst),
    .ld_i      (ratio_ld_i),
    .ratio_i   (ratio_t'(ratio_i)),
    .roll_i    (last),
    .start_o   (start),
    .running_o (running),
    .next_o    (next_ratio)
  );

  swallow_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .load_i  (cyc_load),
    .ratio_i (next_ratio),
    .tick_i  (tick),
    .mod9_o  (mod9),
    .last_o  (last)
  );

  dm_prescaler #(.PW(SW_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .run_i  (running),
    .load_i (start),
    .mod9_i (mod9),
    .tick_o (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_pulse_o <= 1'b0;
      div_half_o  <= 1'b0;
      test_o      <= 1'b0;
      ratio_bad_o <= 1'b0;
    end else begin
      div_pulse_o <= last;
      div_half_o  <= div_half_o ^ last;
      test_o      <= test_en_i && div_half_o;
      if (cyc_load) ratio_bad_o <= !ratio_ok(next_ratio);
    end
  end
endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk
  import pswallow_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic ratio_ld_i,
  input logic test_en_i,
  input logic div_pulse_o,
  input logic div_half_o,
  input logic test_o
);
  localparam int unsigned GAP_MAX = ((2**SW_W) + 1) * (2**MN_W) + 4;

  int unsigned gap;
  logic        armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap   <= 0;
      armed <= 1'b0;
    end else begin
      if (ratio_ld_i) armed <= 1'b1;
      if (div_pulse_o || ratio_ld_i) gap <= 0;
      else if (armed) gap <= gap + 1;
    end
  end

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    div_pulse_o |=> !div_pulse_o);

  assert_half_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    div_pulse_o |-> (div_half_o != $past(div_half_o)));

  assert_half_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !div_pulse_o |-> $stable(div_half_o));

  assert_test_gated_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(test_en_i) |-> !test_o);

  assert_test_follows_R6: assert property (@(posedge clk) disable iff (rst)
    test_o |-> $past(div_half_o));

  assert_gap_bounded_R9: assert property (@(posedge clk) disable iff (rst)
    gap <= GAP_MAX);
endmodule

bind pswallow_div pswallow_div_chk u_chk (.*);

// File: tb/sim_pswallow_div.sv
module sim_pswallow_div;
  localparam int CLK_PER = 10;
  localparam int WD_MAX  = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] ratio_i = '0;
  logic        ratio_ld_i = 1'b0;
  logic        test_en_i = 1'b0;
  logic        div_pulse_o, div_half_o, test_o, ratio_bad_o;

  int total = 0;
  int bad   = 0;
  int pulses = 0;
  int cyc = 0;

  always #(CLK_PER/2) clk = ~clk;

  pswallow_div u0 (
    .clk(clk), .rst(rst), .ratio_i(ratio_i), .ratio_ld_i(ratio_ld_i),
    .test_en_i(test_en_i), .div_pulse_o(div_pulse_o), .div_half_o(div_half_o),
    .test_o(test_o), .ratio_bad_o(ratio_bad_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int m, input int a);
    ratio_i    = 15'((m << 3) | a);
    ratio_ld_i = 1'b1;
  endtask

  // Counts cycles up to and including the next pulse; starts at a pulse negedge.
  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        ratio_ld_i = 1'b0;
        check("R6 test pin", int'(test_o), test_en_i ? (pulses % 2) : 0);
        check("R3 pulse width", int'(div_pulse_o), 0);
      end
    end while (!div_pulse_o);
    pulses++;
    check("R5 half rate", int'(div_half_o), pulses % 2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_MAX) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WD_MAX);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int n;
    int seen;
    repeat (5) @(negedge clk);
    check("R1 reset pulse", int'(div_pulse_o), 0);
    check("R1 reset bad", int'(ratio_bad_o), 0);
    rst = 1'b0;
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (div_pulse_o || div_half_o || test_o || ratio_bad_o) seen++;
    end
    check("R1 idle outputs", seen, 0);

    // First load starts at once (R4); period must be at most the ratio plus start-up.
    test_en_i = 1'b1;
    load(1, 0);
    measure(n);
    check("R4 first start", int'(n <= 8 + 3), 1);

    // Sweep of valid main/swallow pairs (R2); M=1,A=0 is the minimum (R8).
    for (int m = 1; m <= 10; m++) begin
      for (int a = 0; a <= 7 && a <= m; a++) begin
        test_en_i = (m <= 5);
        load(m, a);
        measure(n);
        check("R7 flag clear", int'(ratio_bad_o), 0);
        measure(n);
        check((m == 1 && a == 0) ? "R8 minimum" : "R2 period", n, 8 * m + a);
      end
    end

    // Mid-period reload does not truncate the running period (R4).
    load(6, 3);
    measure(n);
    measure(n);
    check("R2 period 51", n, 51);
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    load(3, 1);
    do begin
      @(negedge clk);
      n++;
      ratio_ld_i = 1'b0;
    end while (!div_pulse_o);
    pulses++;
    check("R4 no truncation", n, 51);
    measure(n);
    check("R4 new ratio", n, 25);

    // Invalid word M<A raises the flag (R7); its period is not checked.
    load(2, 5);
    measure(n);
    check("R7 flag set", int'(ratio_bad_o), 1);
    load(1, 1);
    measure(n);
    check("R7 flag cleared", int'(ratio_bad_o), 0);
    measure(n);
    check("R2 period 9", n, 9);

    // Maximum ratio (R8).
    load(4095, 7);
    measure(n);
    measure(n);
    check("R8 maximum", n, 32767);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule